// File: doc/BRIEF.md
# Sampling Phase Sweep Search

This block picks the best sampling phase for a receiver. It works from a stored, oversampled waveform that covers exactly one period of a test pattern. For every phase offset inside the symbol it takes one sample from each symbol. It then adds up the baud-rate type-A (Mueller-Muller) timing error over the whole pattern. Last, it reports the offset whose total error lies closest to zero. The search runs once for each start request.

The waveform lives in an external memory with synchronous read. The block drives the address and read enable itself, and read data comes back one cycle later. The pattern is treated as circular: the symbol before the first one is the last symbol of the pattern. With the default parameters there are 16 samples per symbol and 127 symbols, which is one PRBS7 period of ±level symbols. That gives 2032 samples. When the search finishes, the block raises a done pulse. The chosen offset and all sixteen signed sums stay on the outputs for a later tuning step to read.

Top module: `phase_sweep_search`

## Requirements
- R1: Each of the SPS offsets (default 16) is evaluated. The sum for offset p uses only samples at offset p within each symbol.
- R2: The memory address of symbol s at offset p is s*SPS + p. One read is issued per cycle while running, and read data is taken on the cycle after the read. Addresses never reach SPS*NSYM.
- R3: The prior sample is circular. For symbol 0 the prior sample is taken from symbol NSYM-1 at the same offset. For symbol k>0 it is taken from symbol k-1.
- R4: The error per symbol is cur*sgn(prev) - prev*sgn(cur). Here sgn is +1 for a positive sample, -1 for a negative one and 0 for zero. Samples are 8-bit two's complement.
- R5: Each offset's total is a signed 24-bit value. It is presented on phaseSums bits [p*24 +: 24] for offset p.
- R6: bestPhase is the offset whose total has the smallest absolute value. On a tie the lower offset wins, so an all-zero waveform yields 0.
- R7: done is high for exactly one cycle, SPS*(NSYM+1)+2 clock edges after the edge that samples start (2050 by default). busy is high from the cycle after that edge, through the done cycle, and falls one cycle later.
- R8: start is ignored while busy is high. The running search keeps its timing and produces exactly one done.
- R9: After done, bestPhase and phaseSums keep their values until the next accepted start.
- R10: After reset, done and busy are 0, bestPhase is 0 and all sums are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one search (taken only when idle) |
| memRdEn | output | 1 | Read enable to waveform memory |
| memAddr | output | 11 | Read address, symbol*SPS + offset |
| memData | input | 8 | Signed sample, valid the cycle after the read |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| bestPhase | output | 4 | Offset with minimum absolute total |
| phaseSums | output | 384 | Sixteen signed 24-bit totals, offset p at [p*24 +: 24] |

## Verification
The assertions take for granted that memData carries the sample for the address issued on the previous cycle. They also take for granted that the memory contents do not change during a search, since the hold and minimum checks rely on totals that come only from that read stream. The bench models a one-cycle synchronous memory and writes the waveform only while the block is idle. It keeps sample magnitudes inside 8 bits so that no total can approach the 24-bit limit. Start pulses sent during a run check that the control keeps its own sequence.

// File: rtl/phase_sweep_pkg.sv
package phase_sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ctrl_state_e;

  // strobes travelling with each returned sample
  typedef struct packed {
    logic valid;  // a sample is on memData this cycle
    logic first;  // it is the prior sample of the circular pair chain
    logic last;   // it closes the current offset
  } strobe_t;

endpackage

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl
  import phase_sweep_pkg::*;
#(
  parameter int SPS     = 16,
  parameter int NSYM    = 127,
  parameter int PHASE_W = $clog2(SPS),
  parameter int ADDR_W  = $clog2(SPS * NSYM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               doneIn,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memAddr,
  output strobe_t            strb,
  output logic [PHASE_W-1:0] strbPhase,
  output logic               busy
);

  localparam int SYM_W = $clog2(NSYM + 1);

  ctrl_state_e        state;
  logic [PHASE_W-1:0] phaseCnt;
  logic [SYM_W-1:0]   stepCnt;   // 0 = prior read of last symbol, 1..NSYM = symbol k-1
  logic [SYM_W-1:0]   symIdx;
  logic               stepEnd;
  logic               lastIssue;

  assign stepEnd   = (stepCnt == SYM_W'(NSYM));
  assign lastIssue = stepEnd && (phaseCnt == PHASE_W'(SPS - 1));
  assign symIdx    = (stepCnt == '0) ? SYM_W'(NSYM - 1) : stepCnt - SYM_W'(1);
  assign memAddr   = ADDR_W'(symIdx) * ADDR_W'(SPS) + ADDR_W'(phaseCnt);
  assign memRdEn   = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      stepCnt   <= '0;
      strb      <= '0;
      strbPhase <= '0;
    end else begin
      strb <= '0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            phaseCnt <= '0;
            stepCnt  <= '0;
          end
        end
        ST_RUN: begin
          strb.valid <= 1'b1;
          strb.first <= (stepCnt == '0);
          strb.last  <= stepEnd;
          strbPhase  <= phaseCnt;
          if (stepEnd) begin
            stepCnt  <= '0;
            phaseCnt <= phaseCnt + PHASE_W'(1);
            if (lastIssue) state <= ST_DRAIN;
          end else begin
            stepCnt <= stepCnt + SYM_W'(1);
          end
        end
        ST_DRAIN: begin
          if (doneIn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: every issued address lies inside the stored pattern
  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr < ADDR_W'(SPS * NSYM)));

  // R7: the search only releases busy right after the completion pulse
  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(doneIn));

endmodule

// File: rtl/phase_sweep_datapath.sv
module phase_sweep_datapath
  import phase_sweep_pkg::*;
#(
  parameter int SPS      = 16,
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 24,
  parameter int PHASE_W  = $clog2(SPS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [PHASE_W-1:0]         strbPhase,
  input  logic signed [SAMPLE_W-1:0] memData,
  output logic                       sumDone,
  output logic signed [SUM_W-1:0]    sumVal,
  output logic [PHASE_W-1:0]         sumPhase,
  output logic [SPS*SUM_W-1:0]       phaseSums
);

  localparam int ERR_W = SAMPLE_W + 2;

  // value times the sign (+1, 0, -1) of another value
  function automatic logic signed [ERR_W-1:0] signTimes(
    input logic signed [SAMPLE_W-1:0] v,
    input logic signed [SAMPLE_W-1:0] s
  );
    logic signed [ERR_W-1:0] vx;
    vx = ERR_W'(v);
    if (s > 0)      return vx;
    else if (s < 0) return -vx;
    else            return '0;
  endfunction

  logic signed [SAMPLE_W-1:0] prevSample;
  logic signed [SUM_W-1:0]    acc;
  logic signed [ERR_W-1:0]    mmErr;
  logic signed [SUM_W-1:0]    newAcc;
  logic                       closeSum;

  assign mmErr    = signTimes(memData, prevSample) - signTimes(prevSample, memData);
  assign newAcc   = acc + SUM_W'(mmErr);
  assign closeSum = strb.valid && strb.last;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= '0;
      acc        <= '0;
      sumDone    <= 1'b0;
      sumVal     <= '0;
      sumPhase   <= '0;
    end else begin
      sumDone <= closeSum;
      if (strb.valid) begin
        prevSample <= memData;
        if (strb.first) acc <= '0;
        else            acc <= newAcc;
      end
      if (closeSum) begin
        sumVal   <= newAcc;
        sumPhase <= strbPhase;
      end
    end
  end

  // one total register per offset
  for (genvar g = 0; g < SPS; g++) begin : g_sum
    logic signed [SUM_W-1:0] sumReg;
    always_ff @(posedge clk) begin
      if (!rstN) sumReg <= '0;
      else if (closeSum && strbPhase == PHASE_W'(g)) sumReg <= newAcc;
    end
    assign phaseSums[g*SUM_W +: SUM_W] = sumReg;
  end

  // R9: totals change only on the edge that closes an offset
  assert_sums_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !closeSum |=> $stable(phaseSums));

  // R1: a closing strobe is never also the opening prior read
  assert_close_not_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    closeSum |-> !strb.first);

endmodule

// File: rtl/phase_sweep_select.sv
module phase_sweep_select #(
  parameter int SPS     = 16,
  parameter int SUM_W   = 24,
  parameter int PHASE_W = $clog2(SPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sumDone,
  input  logic signed [SUM_W-1:0] sumVal,
  input  logic [PHASE_W-1:0]      sumPhase,
  output logic                    done,
  output logic [PHASE_W-1:0]      bestPhase
);

  logic [SUM_W-1:0] absVal;
  logic [SUM_W-1:0] bestAbs;
  logic             takeNew;

  assign absVal  = sumVal[SUM_W-1] ? SUM_W'(-sumVal) : SUM_W'(sumVal);
  // strict compare keeps the lower offset on a tie
  assign takeNew = (sumPhase == '0) || (absVal < bestAbs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestAbs   <= '0;
      bestPhase <= '0;
      done      <= 1'b0;
    end else begin
      done <= sumDone && (sumPhase == PHASE_W'(SPS - 1));
      if (sumDone && takeNew) begin
        bestAbs   <= absVal;
        bestPhase <= sumPhase;
      end
    end
  end

  // R6: the kept magnitude never exceeds the one just offered
  assert_best_minimum_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sumDone && sumPhase != '0) |=> (bestAbs <= $past(absVal)));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: the chosen offset moves only when a total is offered
  assert_best_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sumDone |=> $stable(bestPhase));

endmodule

// File: rtl/phase_sweep_search.sv
module phase_sweep_search
  import phase_sweep_pkg::*;
#(
  parameter int SPS      = 16,
  parameter int NSYM     = 127,
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 24,
  localparam int PHASE_W = $clog2(SPS),
  localparam int ADDR_W  = $clog2(SPS * NSYM)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  output logic                       memRdEn,
  output logic [ADDR_W-1:0]          memAddr,
  input  logic signed [SAMPLE_W-1:0] memData,
  output logic                       busy,
  output logic                       done,
  output logic [PHASE_W-1:0]         bestPhase,
  output logic [SPS*SUM_W-1:0]       phaseSums
);

  strobe_t                 strb;
  logic [PHASE_W-1:0]      strbPhase;
  logic                    sumDone;
  logic signed [SUM_W-1:0] sumVal;
  logic [PHASE_W-1:0]      sumPhase;

  phase_sweep_ctrl #(
    .SPS(SPS), .NSYM(NSYM), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .doneIn(done),
    .memRdEn(memRdEn), .memAddr(memAddr),
    .strb(strb), .strbPhase(strbPhase), .busy(busy)
  );

  phase_sweep_datapath #(
    .SPS(SPS), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .PHASE_W(PHASE_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .strbPhase(strbPhase),
    .memData(memData), .sumDone(sumDone), .sumVal(sumVal),
    .sumPhase(sumPhase), .phaseSums(phaseSums)
  );

  phase_sweep_select #(
    .SPS(SPS), .SUM_W(SUM_W), .PHASE_W(PHASE_W)
  ) uSel (
    .clk(clk), .rstN(rstN), .sumDone(sumDone), .sumVal(sumVal),
    .sumPhase(sumPhase), .done(done), .bestPhase(bestPhase)
  );

endmodule

// File: tb/tb_phase_sweep_search.sv
`timescale 1ns/1ps
module tb_phase_sweep_search;

  localparam int SPS   = 16;
  localparam int NSYM  = 127;
  localparam int SUM_W = 24;
  localparam int LEN   = SPS * NSYM;
  localparam int LAT   = SPS * (NSYM + 1) + 2;

  // {kind, center, rise, fall, amp}; kind 0 PRBS7, 1 clock pattern, 2 sparse wrap, 3 all zero
  localparam logic [39:0] VECS [5] = '{
    {8'd0, 8'd20, 8'd8,  8'd16, 8'd40},
    {8'd0, 8'd24, 8'd12, 8'd6,  8'd30},
    {8'd1, 8'd20, 8'd8,  8'd16, 8'd40},
    {8'd2, 8'd0,  8'd0,  8'd0,  8'd0},
    {8'd3, 8'd0,  8'd0,  8'd0,  8'd0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic              memRdEn;
  logic [10:0]       memAddr;
  logic signed [7:0] memData;
  logic              busy;
  logic              done;
  logic [3:0]        bestPhase;
  logic [SPS*SUM_W-1:0] phaseSums;

  logic signed [7:0] mem [LEN];
  int waveAcc [LEN];
  int expSum [SPS];
  int expBest;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (memRdEn) memData <= mem[memAddr];

  phase_sweep_search dut (
    .clk(clk), .rstN(rstN), .start(start),
    .memRdEn(memRdEn), .memAddr(memAddr), .memData(memData),
    .busy(busy), .done(done), .bestPhase(bestPhase), .phaseSums(phaseSums)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sgnMul(input int v, input int s);
    return (s > 0) ? v : (s < 0) ? -v : 0;
  endfunction

  function automatic int pulseAt(input int m, input int c, input int r, input int f, input int a);
    if (m <= c && m > c - r) return a * (m - (c - r)) / r;
    if (m > c && m < c + f)  return a * (c + f - m) / f;
    return 0;
  endfunction

  function automatic int sumAt(input int p);
    return int'($signed(phaseSums[p*SUM_W +: SUM_W]));
  endfunction

  task automatic buildWave(input logic [39:0] v);
    int kind, c, r, f, a;
    logic [6:0] lfsr;
    kind = int'(v[39:32]); c = int'(v[31:24]); r = int'(v[23:16]);
    f = int'(v[15:8]); a = int'(v[7:0]);
    for (int n = 0; n < LEN; n++) waveAcc[n] = 0;
    lfsr = 7'h7F;
    if (kind <= 1) begin
      for (int k = 0; k < NSYM; k++) begin
        int lvl;
        if (kind == 0) begin
          lvl = lfsr[6] ? 1 : -1;
          lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        end else begin
          lvl = (k % 2 == 0) ? 1 : -1;
        end
        for (int m = 0; m < 64; m++)
          waveAcc[(k * SPS + m) % LEN] += lvl * pulseAt(m, c, r, f, a);
      end
    end else if (kind == 2) begin
      for (int p = 0; p < SPS; p++) begin
        waveAcc[p] = 10 + 5 * p;
        waveAcc[(NSYM - 1) * SPS + p] = -(60 - 3 * p);
      end
    end
    for (int n = 0; n < LEN; n++) begin
      int x;
      x = waveAcc[n];
      if (x > 127) x = 127;
      if (x < -128) x = -128;
      mem[n] = 8'(x);
    end
  endtask

  task automatic model();
    int bestAbs;
    expBest = 0;
    bestAbs = 0;
    for (int p = 0; p < SPS; p++) begin
      int s;
      s = 0;
      for (int k = 0; k < NSYM; k++) begin
        int cur, prv;
        cur = int'(mem[k * SPS + p]);
        prv = int'(mem[((k + NSYM - 1) % NSYM) * SPS + p]);
        s += sgnMul(cur, prv) - sgnMul(prv, cur);
      end
      expSum[p] = s;
      if (p == 0 || (s < 0 ? -s : s) < bestAbs) begin
        bestAbs = (s < 0) ? -s : s;
        expBest = p;
      end
    end
  endtask

  // returns edges from the start-sampling edge to the done cycle and how many done pulses were seen
  task automatic runSearch(input int pokeAt, output int lat, output int pulses);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 0;
    pulses = 0;
    do begin
      @(negedge clk);
      lat++;
      start = (lat == pokeAt);
    end while (!done && lat < 5000);
    if (done) pulses = 1;
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, pulses;
    rstN = 1'b0;
    start = 1'b0;
    for (int n = 0; n < LEN; n++) mem[n] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "done", int'(done), 0);
    check("R10", "busy", int'(busy), 0);
    check("R10", "bestPhase", int'(bestPhase), 0);
    check("R10", "sum7", sumAt(7), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int vi = 0; vi < 5; vi++) begin
      buildWave(VECS[vi]);
      model();
      runSearch(-1, lat, pulses);
      // R7: completion timing
      check("R7", "latency", lat, LAT);
      check("R7", "busy at done", int'(busy), 1);
      for (int p = 0; p < SPS; p++)
        // R1 R3 R4 R5: per-offset totals (vector 3 isolates the circular pair)
        check(vi == 3 ? "R3" : "R1 R4 R5", $sformatf("vec%0d sum%0d", vi, p), sumAt(p), expSum[p]);
      // R6: minimum magnitude, lower index on ties (vector 4 is all zero)
      check("R6", $sformatf("vec%0d bestPhase", vi), int'(bestPhase), expBest);
      @(negedge clk);
      check("R7", "done width", int'(done), 0);
      check("R7", "busy release", int'(busy), 0);
    end

    // R8: start pulse mid-run is ignored
    buildWave(VECS[1]);
    model();
    runSearch(500, lat, pulses);
    check("R8", "latency with extra start", lat, LAT);
    check("R8", "bestPhase", int'(bestPhase), expBest);
    begin
      int extra;
      extra = 0;
      for (int i = 0; i < LAT + 50; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R8", "extra done pulses", extra, 0);
      check("R8", "busy after run", int'(busy), 0);
    end

    // R9: results hold while idle even when memory changes
    for (int n = 0; n < LEN; n++) mem[n] = 8'sd5;
    repeat (40) @(negedge clk);
    check("R9", "bestPhase hold", int'(bestPhase), expBest);
    check("R9", "sum0 hold", sumAt(0), expSum[0]);
    check("R9", "sum15 hold", sumAt(15), expSum[15]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule